// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetch Channel

This block fetches a video frame buffer from memory and streams it out as 32-bit pixel words. What the channel does is set by a descriptor of three words: the byte address where the frame starts, a control word, and the address of the next descriptor. Software puts a first descriptor into the channel through a small write-only register port. It then starts the channel with a single command write that sets enable and update together.

The frame is read in incrementing bursts of four beats from consecutive addresses, because a line stride of zero means the lines sit back to back. The number of words in a frame comes from three inputs: pixels per line, lines per frame and a pixel-width select. Beats that a burst returns past the end of the frame are thrown away. At the end of a frame, the fetch flag in the control word decides what happens next. If the flag is clear, the same start address is read again. If it is set, the channel reads the descriptor at the next pointer and moves to it. A descriptor whose next pointer is its own address therefore refreshes one frame forever, through the descriptor path.

Three event sources drive three interrupt lines. They are address-fetched (a frame starts), descriptor-loaded and end-of-frame. Each source has a sticky status bit, an enable bit in the current control word, and a global mask bit. The mask bits are set and cleared by write-ones registers.

Top module: `frame_dma_ch`

## Requirements
- R1: After reset, mem_req, pix_valid, pix_last and all irq bits are 0, and every interrupt source is masked.
- R2: The channel starts only when idle and only on a write to offset 3 with bit 0 (enable) and bit 1 (update) both set. A write with bit 0 alone issues no memory request.
- R3: A frame is read in bursts of four 32-bit beats. The bursts start at the frame start address and advance 16 bytes each. mem_req and mem_addr hold steady until mem_gnt.
- R4: A frame has lpf × wpl words, where wpl is ppl when cfg_bpp32 is 1 and ceil(ppl/2) when it is 0. Beats past this count are dropped. pix_last marks the final word of the frame.
- R5: When control bit 0 (fetch) is clear, the next frame starts again at the same start address.
- R6: When fetch is set, the channel reads one burst at the next pointer after each frame. It takes the beats in the order start address, control, next pointer and ignores the fourth. It then streams from the new start address. A self-pointing descriptor repeats its own frame.
- R7: Control bits 1, 2 and 3 enable irq[0] (address-fetched), irq[1] (descriptor-loaded) and irq[2] (end-of-frame). The enables come from the descriptor now in use.
- R8: Each status bit is set by its event and stays set until software writes a one to it at offset 6. irq[k] is status[k] AND enable[k] AND NOT mask[k].
- R9: A one written to offset 4 masks the matching source. A one written to offset 5 unmasks it.
- R10: A write to offset 3 with bit 0 clear stops the channel at the end of the frame in progress. No request follows that frame.
- R11: The geometry inputs are sampled when a frame begins. A change during a frame does not alter that frame's length.
- R12: Offsets 0, 1 and 2 take the start address, the control word and the next pointer that the start command loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| cfg_ppl | input | 12 | Pixels per line |
| cfg_lpf | input | 12 | Lines per frame |
| cfg_bpp32 | input | 1 | 1: one pixel per word, 0: two pixels per word |
| mem_req | output | 1 | Burst request |
| mem_addr | output | 32 | Burst byte address |
| mem_gnt | input | 1 | Burst accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| pix_valid | output | 1 | Pixel word valid |
| pix_data | output | 32 | Pixel word |
| pix_last | output | 1 | Final word of a frame |
| irq | output | 3 | Address-fetched, descriptor-loaded, end-of-frame |

## Verification
The first stimulus is a 16-bit frame of six words. It leaves two beats of its second burst to be dropped and runs twice without fetch, which separates restarting at the same address from wrapping to the next burst. A 32-bit frame of five words is served with slow grants. That run tells request holding and tail discard apart from plain streaming, and its end-of-frame interrupt is then masked, unmasked and cleared. A descriptor chain follows: a software descriptor points to a self-looping one, and the grant log and data order show whether the next pointer, the beat order and the self-loop are followed. A geometry change in the middle of a frame and an enable write without update check the sampling point and the start condition.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_FDATA,
    ST_DREQ,
    ST_DDATA
  } fdma_state_e;

  // control word bits
  localparam int CTL_W       = 4;
  localparam int CTL_FETCH   = 0;
  localparam int CTL_IE_ADDR = 1;
  localparam int CTL_IE_DSCR = 2;
  localparam int CTL_IE_END  = 3;

  // event / interrupt indices
  localparam int NEV     = 3;
  localparam int EV_ADDR = 0;
  localparam int EV_DSCR = 1;
  localparam int EV_END  = 2;

  // register offsets
  localparam logic [2:0] REG_ADDR = 3'd0;
  localparam logic [2:0] REG_CTRL = 3'd1;
  localparam logic [2:0] REG_NEXT = 3'd2;
  localparam logic [2:0] REG_CMD  = 3'd3;
  localparam logic [2:0] REG_MSET = 3'd4;
  localparam logic [2:0] REG_MCLR = 3'd5;
  localparam logic [2:0] REG_SCLR = 3'd6;

  // words in one frame: lines times words per line
  function automatic logic [31:0] frame_word_count(input logic [31:0] ppl,
                                                   input logic [31:0] lpf,
                                                   input logic        wide);
    logic [31:0] wpl;
    wpl = wide ? ppl : ((ppl + 32'd1) >> 1);
    return wpl * lpf;
  endfunction

endpackage

// File: rtl/fdma_regs.sv
module fdma_regs #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [2:0]               reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  input  logic                     busy,
  output logic [AW-1:0]            pend_addr,
  output logic [fdma_pkg::CTL_W-1:0] pend_ctrl,
  output logic [AW-1:0]            pend_next,
  output logic                     chan_en,
  output logic                     start,
  output logic                     mask_set_wr,
  output logic                     mask_clr_wr,
  output logic                     stat_clr_wr
);
  import fdma_pkg::*;

  logic cmd_wr;
  assign cmd_wr      = reg_wr && (reg_addr == REG_CMD);
  assign start       = cmd_wr && reg_wdata[0] && reg_wdata[1] && !busy;
  assign mask_set_wr = reg_wr && (reg_addr == REG_MSET);
  assign mask_clr_wr = reg_wr && (reg_addr == REG_MCLR);
  assign stat_clr_wr = reg_wr && (reg_addr == REG_SCLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pend_ctrl <= '0;
      pend_next <= '0;
      chan_en   <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        REG_ADDR: pend_addr <= reg_wdata[AW-1:0];
        REG_CTRL: pend_ctrl <= reg_wdata[CTL_W-1:0];
        REG_NEXT: pend_next <= reg_wdata[AW-1:0];
        REG_CMD:  chan_en   <= reg_wdata[0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/fdma_irq.sv
module fdma_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] ie,
  input  logic [NSRC-1:0] wbits,
  input  logic            mask_set_wr,
  input  logic            mask_clr_wr,
  input  logic            stat_clr_wr,
  output logic [NSRC-1:0] irq
);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic st_q;
    logic mk_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= 1'b0;
        mk_q <= 1'b1;
      end else begin
        // a new event wins over a clear in the same cycle
        st_q <= ev[k] | (st_q & ~(stat_clr_wr & wbits[k]));
        if (mask_set_wr && wbits[k])
          mk_q <= 1'b1;
        else if (mask_clr_wr && wbits[k])
          mk_q <= 1'b0;
      end
    end

    assign irq[k] = st_q & ie[k] & ~mk_q;
  end

endmodule

// File: rtl/fdma_seq.sv
module fdma_seq #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BURST = 4,
  parameter int GEO_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       chan_en,
  input  logic [AW-1:0]              pend_addr,
  input  logic [fdma_pkg::CTL_W-1:0] pend_ctrl,
  input  logic [AW-1:0]              pend_next,
  input  logic [GEO_W-1:0]           cfg_ppl,
  input  logic [GEO_W-1:0]           cfg_lpf,
  input  logic                       cfg_bpp32,
  output logic                       mem_req,
  output logic [AW-1:0]              mem_addr,
  input  logic                       mem_gnt,
  input  logic                       mem_rvalid,
  input  logic [DW-1:0]              mem_rdata,
  output logic                       pix_valid,
  output logic [DW-1:0]              pix_data,
  output logic                       pix_last,
  output logic [fdma_pkg::CTL_W-1:0] cur_ctrl,
  output logic                       busy,
  output logic                       ev_addr,
  output logic                       ev_dscr,
  output logic                       ev_end
);
  import fdma_pkg::*;

  localparam int CNT_W  = 2 * GEO_W;
  localparam int BEAT_W = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [AW-1:0]     BURST_BYTES = AW'(BURST * 4);
  localparam logic [BEAT_W-1:0] LAST_BEAT   = BEAT_W'(BURST - 1);

  fdma_state_e        state;
  logic [BEAT_W-1:0]  beat;
  logic [CNT_W-1:0]   word_cnt;
  logic [CNT_W-1:0]   frame_total;
  logic [AW-1:0]      burst_base;
  logic [AW-1:0]      cur_addr;
  logic [AW-1:0]      cur_next;
  logic [AW-1:0]      d_addr;
  logic [CTL_W-1:0]   d_ctrl;
  logic [AW-1:0]      d_next;

  // named internal events
  logic take;
  logic last_take;
  logic burst_done;
  logic frame_done;
  logic sw_load;
  logic desc_done;
  logic restart;
  logic [CNT_W-1:0] geo_total;

  assign geo_total  = CNT_W'(frame_word_count(32'(cfg_ppl), 32'(cfg_lpf), cfg_bpp32));
  assign take       = (state == ST_FDATA) && mem_rvalid && (word_cnt < frame_total);
  assign last_take  = take && ((word_cnt + 1'b1) == frame_total);
  assign burst_done = mem_rvalid && (beat == LAST_BEAT);
  assign frame_done = (word_cnt + CNT_W'(take)) >= frame_total;
  assign sw_load    = (state == ST_IDLE) && start;
  assign desc_done  = (state == ST_DDATA) && burst_done;
  assign ev_end     = (state == ST_FDATA) && burst_done && frame_done;
  assign restart    = ev_end && chan_en && !cur_ctrl[CTL_FETCH];
  assign ev_dscr    = sw_load || desc_done;
  assign ev_addr    = sw_load || desc_done || restart;

  assign mem_req  = (state == ST_FREQ) || (state == ST_DREQ);
  assign mem_addr = (state == ST_DREQ) ? cur_next : burst_base;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      beat        <= '0;
      word_cnt    <= '0;
      frame_total <= '0;
      burst_base  <= '0;
      cur_addr    <= '0;
      cur_ctrl    <= '0;
      cur_next    <= '0;
      d_addr      <= '0;
      d_ctrl      <= '0;
      d_next      <= '0;
      pix_valid   <= 1'b0;
      pix_data    <= '0;
      pix_last    <= 1'b0;
    end else begin
      pix_valid <= take;
      pix_last  <= last_take;
      if (take) pix_data <= mem_rdata;
      case (state)
        ST_IDLE: begin
          if (start) begin
            cur_addr    <= pend_addr;
            cur_ctrl    <= pend_ctrl;
            cur_next    <= pend_next;
            burst_base  <= pend_addr;
            word_cnt    <= '0;
            frame_total <= geo_total;
            state       <= ST_FREQ;
          end
        end
        ST_FREQ: begin
          if (mem_gnt) begin
            beat  <= '0;
            state <= ST_FDATA;
          end
        end
        ST_FDATA: begin
          if (mem_rvalid) begin
            beat <= beat + 1'b1;
            if (take) word_cnt <= word_cnt + 1'b1;
            if (burst_done) begin
              burst_base <= burst_base + BURST_BYTES;
              if (!frame_done) begin
                state <= ST_FREQ;
              end else if (!chan_en) begin
                state <= ST_IDLE;
              end else if (cur_ctrl[CTL_FETCH]) begin
                state <= ST_DREQ;
              end else begin
                burst_base  <= cur_addr;
                word_cnt    <= '0;
                frame_total <= geo_total;
                state       <= ST_FREQ;
              end
            end
          end
        end
        ST_DREQ: begin
          if (mem_gnt) begin
            beat  <= '0;
            state <= ST_DDATA;
          end
        end
        ST_DDATA: begin
          if (mem_rvalid) begin
            beat <= beat + 1'b1;
            if (beat == BEAT_W'(0)) d_addr <= mem_rdata[AW-1:0];
            if (beat == BEAT_W'(1)) d_ctrl <= mem_rdata[CTL_W-1:0];
            if (beat == BEAT_W'(2)) d_next <= mem_rdata[AW-1:0];
            if (burst_done) begin
              cur_addr    <= d_addr;
              cur_ctrl    <= d_ctrl;
              cur_next    <= d_next;
              burst_base  <= d_addr;
              word_cnt    <= '0;
              frame_total <= geo_total;
              state       <= ST_FREQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/frame_dma_ch.sv
module frame_dma_ch #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BURST = 4,
  parameter int GEO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [GEO_W-1:0] cfg_ppl,
  input  logic [GEO_W-1:0] cfg_lpf,
  input  logic             cfg_bpp32,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             pix_valid,
  output logic [DW-1:0]    pix_data,
  output logic             pix_last,
  output logic [2:0]       irq
);
  import fdma_pkg::*;

  logic [AW-1:0]    pend_addr;
  logic [CTL_W-1:0] pend_ctrl;
  logic [AW-1:0]    pend_next;
  logic [CTL_W-1:0] cur_ctrl;
  logic chan_en, start, busy;
  logic mask_set_wr, mask_clr_wr, stat_clr_wr;
  logic ev_addr, ev_dscr, ev_end;
  logic [NEV-1:0] ev_vec;
  logic [NEV-1:0] ie_vec;

  assign ev_vec = {ev_end, ev_dscr, ev_addr};
  assign ie_vec = {cur_ctrl[CTL_IE_END], cur_ctrl[CTL_IE_DSCR], cur_ctrl[CTL_IE_ADDR]};

  fdma_regs #(.AW(AW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .pend_addr(pend_addr),
    .pend_ctrl(pend_ctrl), .pend_next(pend_next), .chan_en(chan_en),
    .start(start), .mask_set_wr(mask_set_wr), .mask_clr_wr(mask_clr_wr),
    .stat_clr_wr(stat_clr_wr)
  );

  fdma_seq #(.AW(AW), .DW(DW), .BURST(BURST), .GEO_W(GEO_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_en(chan_en),
    .pend_addr(pend_addr), .pend_ctrl(pend_ctrl), .pend_next(pend_next),
    .cfg_ppl(cfg_ppl), .cfg_lpf(cfg_lpf), .cfg_bpp32(cfg_bpp32),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_last(pix_last), .cur_ctrl(cur_ctrl),
    .busy(busy), .ev_addr(ev_addr), .ev_dscr(ev_dscr), .ev_end(ev_end)
  );

  fdma_irq #(.NSRC(NEV)) irq_i (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .ie(ie_vec),
    .wbits(reg_wdata[NEV-1:0]), .mask_set_wr(mask_set_wr),
    .mask_clr_wr(mask_clr_wr), .stat_clr_wr(stat_clr_wr), .irq(irq)
  );

endmodule

// File: rtl/fdma_chk.sv
module fdma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          pix_valid,
  input logic          pix_last,
  input logic [2:0]    irq,
  input logic          ev_end,
  input logic          ev_dscr,
  input logic          wr_mset_end,
  input logic          wr_mclr
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R3

  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pix_last |-> pix_valid); // R4

  AST_PIX_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(mem_rvalid)); // R4

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset_end |=> !irq[2]); // R9

  AST_END_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[2]) |-> ($past(ev_end) || $past(ev_dscr) || $past(wr_mclr))); // R8

endmodule

bind frame_dma_ch fdma_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .pix_valid(pix_valid),
  .pix_last(pix_last), .irq(irq), .ev_end(ev_end), .ev_dscr(ev_dscr),
  .wr_mset_end(reg_wr && (reg_addr == fdma_pkg::REG_MSET) && reg_wdata[fdma_pkg::EV_END]),
  .wr_mclr(reg_wr && (reg_addr == fdma_pkg::REG_MCLR))
);

// File: tb/frame_dma_ch_tb.sv
module frame_dma_ch_tb_top;
  localparam int CLK_NS = 10;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [11:0] cfg_ppl, cfg_lpf;
  logic        cfg_bpp32;
  logic        mem_req, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        pix_valid, pix_last;
  logic [31:0] pix_data;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_err = 0;
  int n_gnt = 0;
  int gnt_delay = 0;
  logic [31:0] gnt_log[$];
  logic [31:0] mem_over[logic [31:0]];
  logic [31:0] exp_d[$];
  logic        exp_l[$];
  string       exp_t[$];

  frame_dma_ch dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_ppl(cfg_ppl), .cfg_lpf(cfg_lpf),
    .cfg_bpp32(cfg_bpp32), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_last(pix_last), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_NS/2) clk = ~clk;
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem_over.exists(a)) return mem_over[a];
    return a ^ 32'hC3A5_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected words of one frame
  task automatic push_frame(input logic [31:0] base, input int words, input string req);
    for (int i = 0; i < words; i++) begin
      exp_d.push_back(rd(base + 32'(4 * i)));
      exp_l.push_back(i == words - 1);
      exp_t.push_back(req);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_gnt(input int n);
    while (n_gnt < n) @(negedge clk);
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // memory model: grant after gnt_delay cycles, then four beats
  initial begin
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_gnt = 1'b0; mem_rvalid = 1'b0;
      if (rst_n && mem_req) begin
        logic [31:0] a;
        repeat (gnt_delay) @(negedge clk);
        a = mem_addr;
        mem_gnt = 1'b1;
        gnt_log.push_back(a);
        n_gnt++;
        @(negedge clk);
        mem_gnt = 1'b0;
        for (int b = 0; b < 4; b++) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd(a + 32'(4 * b));
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
      end
    end
  end

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && pix_valid) begin
        if (exp_d.size() == 0) begin
          check("R4 unexpected word", pix_data, 32'hxxxx_xxxx);
        end else begin
          string t;
          logic [31:0] d;
          logic l;
          t = exp_t.pop_front(); d = exp_d.pop_front(); l = exp_l.pop_front();
          check({t, " data"}, pix_data, d);
          check({t, " last"}, 32'(pix_last), 32'(l));
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int base;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cfg_ppl = 12'd6; cfg_lpf = 12'd2; cfg_bpp32 = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 pix_valid", 32'(pix_valid), 0);
    check("R1 irq", 32'(irq), 0);

    // R2: enable without update starts nothing
    wr(3'd3, 32'h1);
    repeat (20) @(negedge clk);
    check("R2 no grant", 32'(n_gnt), 0);
    check("R2 no req", 32'(mem_req), 0);
    wr(3'd3, 32'h0);

    // R5, R11, R10, R12: 16-bit frame of six words, restart without fetch
    wr(3'd0, 32'h100); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
    push_frame(32'h100, 6, "R4 16bpp");
    push_frame(32'h100, 6, "R5 restart");
    base = n_gnt;
    wr(3'd3, 32'h3);
    wait_gnt(base + 3);
    cfg_ppl = 12'd2;               // R11: must not shorten frame 2
    wr(3'd3, 32'h0);               // R10: stop after frame 2
    repeat (60) @(negedge clk);
    check("R10 queue drained", 32'(exp_d.size()), 0);
    check("R10 grant count", 32'(n_gnt), 32'(base + 4));
    check("R3 first burst", gnt_log[base], 32'h100);
    check("R3 second burst", gnt_log[base + 1], 32'h110);
    check("R5 restart addr", gnt_log[base + 2], 32'h100);
    check("R12 start addr", gnt_log[base + 3], 32'h110);

    // R4, R7, R8, R9: 32-bit five-word frame, slow grants, end interrupt
    wr(3'd6, 32'h7);
    wr(3'd5, 32'h7);
    cfg_ppl = 12'd5; cfg_lpf = 12'd1; cfg_bpp32 = 1'b1;
    gnt_delay = 2;
    wr(3'd0, 32'h300); wr(3'd1, 32'h8);
    push_frame(32'h300, 5, "R4 32bpp tail");
    wr(3'd3, 32'h3);
    wr(3'd3, 32'h0);
    repeat (60) @(negedge clk);
    gnt_delay = 0;
    check("R4 queue drained", 32'(exp_d.size()), 0);
    check("R7 only end irq", 32'(irq), 32'h4);
    wr(3'd4, 32'h4);
    check("R9 masked", 32'(irq), 32'h0);
    wr(3'd5, 32'h4);
    check("R9 unmasked", 32'(irq), 32'h4);
    wr(3'd6, 32'h4);
    check("R8 cleared", 32'(irq), 32'h0);

    // R6: software descriptor -> self-looping descriptor at 0x1000
    wr(3'd6, 32'h7);
    mem_over[32'h1000] = 32'h2000;
    mem_over[32'h1004] = 32'h7;
    mem_over[32'h1008] = 32'h1000;
    mem_over[32'h100C] = 32'hDEAD_BEEF;
    cfg_ppl = 12'd4; cfg_lpf = 12'd1; cfg_bpp32 = 1'b1;
    wr(3'd0, 32'h400); wr(3'd1, 32'h1); wr(3'd2, 32'h1000);
    push_frame(32'h400, 4, "R6 first");
    push_frame(32'h2000, 4, "R6 chained");
    push_frame(32'h2000, 4, "R6 self loop");
    base = n_gnt;
    wr(3'd3, 32'h3);
    wait_gnt(base + 5);
    wr(3'd3, 32'h0);
    repeat (60) @(negedge clk);
    check("R6 queue drained", 32'(exp_d.size()), 0);
    check("R6 grant count", 32'(n_gnt), 32'(base + 5));
    check("R6 desc read addr", gnt_log[base + 1], 32'h1000);
    check("R6 self desc addr", gnt_log[base + 3], 32'h1000);
    check("R6 new frame addr", gnt_log[base + 4], 32'h2000);
    check("R7 addr+dscr irq", 32'(irq), 32'h3);

    report();
  end

endmodule